// File: doc/BRIEF.md
# External Memory Bus Cycle Sequencer

This block turns fetch and data-access requests from an 8-bit processor core into cycles on a multiplexed external bus. The address space is 64K for programs and 64K for data. The block runs on the oscillator clock. Each machine cycle is twelve clocks, numbered as phases 0 to 11. Every strobe sits on fixed phases within that frame. The address-latch strobe pulses twice in each machine cycle. The program-read strobe pulses twice in each machine cycle that fetches from off-chip. A data access gives up the second latch pulse and both program-read pulses, and drives one long read or write strobe in their place.

The low address byte and the data byte share one 8-bit port. The low address is driven while the latch strobe is high. Write data or a read return follows on the same port. The high address byte comes from the request address for fetches and for 16-bit-pointer data accesses. For 8-bit indirect data accesses it comes from the port-2 output latch. A strap input is captured while reset is active. It decides whether fetches at or below 7FFFH are served on-chip. Reset is generated from a pin that must stay high for two full machine cycles.

Top module: `ext_bus_seq`

## Requirements
- R1: `core_rst` rises after the 24th consecutive clock edge with `rst_pin` high, and not after the 23rd. It falls on the first edge with `rst_pin` low. While it is high, `ale` is low, `psen_n`, `rd_n` and `wr_n` are high, and `ad_oe` is low.
- R2: Outside reset, `ale` is high in phases 0, 1, 6 and 7 of every machine cycle that is not a data access. Idle cycles and internal fetches are included.
- R3: In a data-access machine cycle, `ale` is high only in phases 0 and 1. The pulse in phases 6 and 7 is omitted.
- R4: An external fetch drives `psen_n` low in phases 3 to 5 and 9 to 11, which is 6 clocks per machine cycle. `rsp_data` returns the `ad_in` value sampled at the end of phase 5.
- R5: A data access keeps `psen_n` high. It drives `rd_n` (kind 01) or `wr_n` (kind 11) low in phases 3 to 9, which is 7 clocks. A read returns the `ad_in` value sampled at the end of phase 9.
- R6: A fetch served on-chip never asserts `psen_n`, never drives `ad_oe`, and reports `rsp_internal` = 1 with `rsp_ready`.
- R7: `ea_strap` is captured only while `core_rst` is high. If the strap is low, every fetch is external. If it is high, only fetches with an address above 7FFFH are external. Changing the strap after reset has no effect.
- R8: `addr_hi` carries `req_addr[15:8]` during an external fetch and during a data access with `req_short` = 0. It carries `p2_latch` during a data access with `req_short` = 1, and at all other times.
- R9: In an external cycle, `ad_oe` is high while `ale` is high, and `ad_out` then carries the low address byte. A write also drives `req_wdata` with `ad_oe` high from phase 2 to phase 11. `ad_oe` is low whenever `rd_n` or `psen_n` is low.
- R10: A request is accepted at the clock edge that ends phase 11 while `req_valid` is high. `req_kind` 00 means fetch, 01 data read, 11 data write, and 10 is treated as a fetch. `rsp_ready` is high for exactly phase 11 of the machine cycle that follows acceptance.
- R11: No two of `psen_n`, `rd_n` and `wr_n` are ever low at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_pin | input | 1 | Raw reset pin, active high |
| ea_strap | input | 1 | Program-mapping strap; high allows on-chip fetch |
| core_rst | output | 1 | Filtered reset to the core |
| req_valid | input | 1 | Access request present |
| req_kind | input | 2 | 00 fetch, 01 data read, 11 data write |
| req_short | input | 1 | Data access uses an 8-bit indirect address |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write data |
| rsp_ready | output | 1 | Access completes in this clock |
| rsp_data | output | 8 | Byte read from the bus |
| rsp_internal | output | 1 | Fetch is served by on-chip memory |
| p2_latch | input | 8 | Port-2 output latch contents |
| ale | output | 1 | Address-latch strobe, active high |
| psen_n | output | 1 | Program-read strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| ad_out | output | 8 | Multiplexed low address / write data |
| ad_oe | output | 1 | Drive enable for `ad_out` |
| ad_in | input | 8 | Multiplexed port input |
| addr_hi | output | 8 | High address byte |

## Verification
The bench builds the block with its defaults: twelve phases per machine cycle, a 24-clock reset filter and an on-chip program limit of 7FFFH. With these values, the 23-clock versus 24-clock reset threshold can be checked edge by edge. The 7FFFH and 8000H fetch addresses fall on either side of the mapping limit. Every strobe position in a machine cycle can be counted directly against the phase numbers in the requirements.

// File: rtl/ext_bus_seq.sv
module ext_bus_seq #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int PHASES = 12,
  parameter int RST_CLKS = 24,
  parameter logic [AW-1:0] INT_LIMIT = 16'h7FFF
) (
  input  logic          clk,
  input  logic          rst_pin,
  input  logic          ea_strap,
  output logic          core_rst,
  input  logic          req_valid,
  input  logic [1:0]    req_kind,
  input  logic          req_short,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_ready,
  output logic [DW-1:0] rsp_data,
  output logic          rsp_internal,
  input  logic [DW-1:0] p2_latch,
  output logic          ale,
  output logic          psen_n,
  output logic          rd_n,
  output logic          wr_n,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  input  logic [DW-1:0] ad_in,
  output logic [DW-1:0] addr_hi
);
  localparam int PW = $clog2(PHASES);
  localparam int CW = $clog2(RST_CLKS + 1);
  localparam int HALF = PHASES / 2;
  localparam logic [PW-1:0] PH_1    = PW'(1);
  localparam logic [PW-1:0] PH_2    = PW'(2);
  localparam logic [PW-1:0] PH_S1   = PW'(3);
  localparam logic [PW-1:0] PH_FE   = PW'(HALF - 1);
  localparam logic [PW-1:0] PH_H0   = PW'(HALF);
  localparam logic [PW-1:0] PH_H1   = PW'(HALF + 1);
  localparam logic [PW-1:0] PH_S2   = PW'(HALF + 3);
  localparam logic [PW-1:0] PH_DE   = PW'(PHASES - 3);
  localparam logic [PW-1:0] PH_LAST = PW'(PHASES - 1);
  localparam logic [CW-1:0] RC_TRIG = CW'(RST_CLKS - 1);

  logic [CW-1:0] rcnt;
  logic          strap_q;
  logic [PW-1:0] ph;
  logic          act, k_data, k_wr, k_short, k_ext;
  logic [AW-1:0] a_q;
  logic [DW-1:0] wd_q, rd_q;

  always_ff @(posedge clk) begin
    if (!rst_pin) rcnt <= '0;
    else if (rcnt != RC_TRIG) rcnt <= rcnt + 1'b1;
    core_rst <= rst_pin && (core_rst || rcnt == RC_TRIG);
    if (core_rst) strap_q <= ea_strap;
  end

  always_ff @(posedge clk) begin
    if (core_rst) begin
      ph  <= '0;
      act <= 1'b0;
    end else begin
      ph <= (ph == PH_LAST) ? '0 : ph + 1'b1;
      if (ph == PH_LAST) begin
        act     <= req_valid;
        k_data  <= req_kind[0];
        k_wr    <= req_kind[0] & req_kind[1];
        k_short <= req_short;
        k_ext   <= req_kind[0] | !strap_q | (req_addr > INT_LIMIT);
        a_q     <= req_addr;
        wd_q    <= req_wdata;
      end
      if (act && k_ext && !k_data && ph == PH_FE) rd_q <= ad_in;
      if (act && k_data && !k_wr && ph == PH_DE) rd_q <= ad_in;
    end
  end

  logic ale_slot, fetch_x, dstrobe, wr_phase;
  assign ale_slot = (ph <= PH_1) || (ph == PH_H0) || (ph == PH_H1);
  assign ale      = !core_rst && ale_slot && !(act && k_data && ph >= PH_H0);
  assign fetch_x  = !core_rst && act && k_ext && !k_data;
  assign psen_n   = !(fetch_x && ((ph >= PH_S1 && ph <= PH_FE) || ph >= PH_S2));
  assign dstrobe  = !core_rst && act && k_data && ph >= PH_S1 && ph <= PH_DE;
  assign rd_n     = !(dstrobe && !k_wr);
  assign wr_n     = !(dstrobe && k_wr);
  assign wr_phase = act && k_data && k_wr && ph >= PH_2;
  assign ad_oe    = !core_rst && act && k_ext && (ale || wr_phase);
  assign ad_out   = !ad_oe ? '0 : (wr_phase ? wd_q : a_q[DW-1:0]);
  assign addr_hi  = (!core_rst && act && k_ext && !(k_data && k_short)) ? a_q[AW-1:AW-DW] : p2_latch;

  assign rsp_ready    = !core_rst && act && ph == PH_LAST;
  assign rsp_data     = rd_q;
  assign rsp_internal = !core_rst && act && !k_ext;
endmodule

// File: rtl/ext_bus_seq_chk.sv
module ext_bus_seq_chk (
  input logic clk,
  input logic rst_pin,
  input logic core_rst,
  input logic ale,
  input logic psen_n,
  input logic rd_n,
  input logic wr_n,
  input logic ad_oe,
  input logic rsp_ready
);
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= armed | core_rst;

  assert_reset_cause_R1: assert property (@(posedge clk) disable iff (!armed)
    $rose(core_rst) |-> $past(rst_pin));
  assert_reset_release_R1: assert property (@(posedge clk) disable iff (!armed)
    !rst_pin |=> !core_rst);
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!armed)
    core_rst |-> (!ale && psen_n && rd_n && wr_n && !ad_oe));
  assert_ale_width_R2: assert property (@(posedge clk) disable iff (!armed || core_rst)
    $fell(ale) |-> $past(ale, 2));
  assert_no_ale_in_data_R3: assert property (@(posedge clk) disable iff (!armed || core_rst)
    (!rd_n || !wr_n) |-> !ale);
  assert_write_driven_R9: assert property (@(posedge clk) disable iff (!armed || core_rst)
    !wr_n |-> ad_oe);
  assert_read_floats_R9: assert property (@(posedge clk) disable iff (!armed || core_rst)
    (!rd_n || !psen_n) |-> !ad_oe);
  assert_ready_single_R10: assert property (@(posedge clk) disable iff (!armed || core_rst)
    rsp_ready |=> !rsp_ready);
  assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (!armed)
    (!rd_n || !wr_n) |-> (psen_n && (rd_n || wr_n)));
endmodule

bind ext_bus_seq ext_bus_seq_chk i_chk (
  .clk(clk), .rst_pin(rst_pin), .core_rst(core_rst), .ale(ale), .psen_n(psen_n),
  .rd_n(rd_n), .wr_n(wr_n), .ad_oe(ad_oe), .rsp_ready(rsp_ready)
);

// File: tb/test_ext_bus_seq.sv
`timescale 1ns/1ps
module test_ext_bus_seq;
  localparam logic [7:0] P2 = 8'h9E;
  // {kind[1:0], short, addr[15:0], wdata[7:0], bus[7:0]}
  localparam logic [34:0] VEC [8] = '{
    {2'b00, 1'b0, 16'h0123, 8'h00, 8'h11},
    {2'b00, 1'b0, 16'h7FFF, 8'h00, 8'h22},
    {2'b00, 1'b0, 16'h8000, 8'h00, 8'h5A},
    {2'b10, 1'b0, 16'hC3A7, 8'h00, 8'h3C},
    {2'b01, 1'b0, 16'h1234, 8'h00, 8'hA5},
    {2'b01, 1'b1, 16'h0045, 8'h00, 8'h66},
    {2'b11, 1'b0, 16'hBEEF, 8'h77, 8'h00},
    {2'b11, 1'b1, 16'h0010, 8'h81, 8'h00}
  };

  logic clk = 0, rst_pin = 0, ea_strap = 1;
  logic req_valid = 0, req_short = 0;
  logic [1:0] req_kind = 0;
  logic [15:0] req_addr = 0;
  logic [7:0] req_wdata = 0, ad_in = 0;
  logic core_rst, rsp_ready, rsp_internal, ale, psen_n, rd_n, wr_n, ad_oe;
  logic [7:0] rsp_data, ad_out, addr_hi;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ext_bus_seq i_ext_bus_seq (
    .clk(clk), .rst_pin(rst_pin), .ea_strap(ea_strap), .core_rst(core_rst),
    .req_valid(req_valid), .req_kind(req_kind), .req_short(req_short),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .rsp_internal(rsp_internal), .p2_latch(P2),
    .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n), .ad_out(ad_out),
    .ad_oe(ad_oe), .ad_in(ad_in), .addr_hi(addr_hi)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  logic s_ale[64], s_psen[64], s_rd[64], s_wr[64], s_oe[64];
  logic [7:0] s_ad[64], s_hi[64];
  int win;

  task automatic run_txn(logic [1:0] kind, logic sh, logic [15:0] addr, logic [7:0] wd,
                         logic [7:0] bus, logic strap_hi);
    int n = 0;
    int na = 0, np = 0, nr = 0, nw = 0;
    logic data, wr, ext;
    logic [7:0] exp_hi;
    req_valid = 1; req_kind = kind; req_short = sh; req_addr = addr;
    req_wdata = wd; ad_in = bus;
    forever begin
      @(negedge clk);
      s_ale[n] = ale; s_psen[n] = psen_n; s_rd[n] = rd_n; s_wr[n] = wr_n;
      s_oe[n] = ad_oe; s_ad[n] = ad_out; s_hi[n] = addr_hi;
      if (rsp_ready || n == 40) break;
      n++;
    end
    req_valid = 0;
    win = n - 11;
    chk("R10 ready within one machine cycle after accept", int'(n >= 11 && n <= 23), 1);
    if (win < 0) win = 0;
    data = kind[0]; wr = kind[0] & kind[1];
    ext = data | !strap_hi | addr[15];
    for (int i = 0; i < 12; i++) begin
      na += s_ale[win+i]; np += !s_psen[win+i]; nr += !s_rd[win+i]; nw += !s_wr[win+i];
    end
    chk(data ? "R3 latch pulses in data cycle" : "R2 latch pulses per cycle", na, data ? 2 : 4);
    chk("R4 program strobe clocks", np, (ext && !data) ? 6 : 0);
    chk("R5 read strobe clocks", nr, (data && !wr) ? 7 : 0);
    chk("R5 write strobe clocks", nw, wr ? 7 : 0);
    exp_hi = (ext && !(data && sh)) ? addr[15:8] : P2;
    chk("R8 high address byte", s_hi[win], exp_hi);
    chk("R9 low address driven with latch", {s_oe[win], s_ad[win]}, ext ? {1'b1, addr[7:0]} : 9'h000);
    if (wr) chk("R9 write data on bus", {s_oe[win+5], s_ad[win+5]}, {1'b1, wd});
    if (!ext) begin
      for (int i = 0; i < 12; i++) chk("R6 no drive on internal fetch", s_oe[win+i], 0);
    end
    chk("R6 internal flag", rsp_internal, !ext);
    if (ext && !wr) chk(data ? "R5 read data" : "R4 fetch data", rsp_data, bus);
  endtask

  task automatic do_reset(logic strap);
    ea_strap = strap; rst_pin = 1;
    repeat (30) @(negedge clk);
    rst_pin = 0;
    @(negedge clk);
  endtask

  initial begin
    int cnt, rc;
    repeat (3) @(negedge clk);
    rst_pin = 1; ea_strap = 1;
    repeat (23) @(negedge clk);
    chk("R1 no reset after 23 clocks", core_rst, 0);
    @(negedge clk);
    chk("R1 reset after 24 clocks", core_rst, 1);
    chk("R1 reset bus state", {ale, psen_n, rd_n, wr_n, ad_oe}, 5'b01110);
    repeat (6) @(negedge clk);
    rst_pin = 0;
    @(negedge clk);
    chk("R1 release", core_rst, 0);

    cnt = 0;
    for (int i = 0; i < 12; i++) begin @(negedge clk); cnt += ale; end
    chk("R2 idle latch pulses", cnt, 4);

    foreach (VEC[i])
      run_txn(VEC[i][34:33], VEC[i][32], VEC[i][31:16], VEC[i][15:8], VEC[i][7:0], 1'b1);

    ea_strap = 0;
    run_txn(2'b00, 1'b0, 16'h0100, 8'h00, 8'h44, 1'b1);
    chk("R7 strap change ignored after reset", rsp_internal, 1);

    rst_pin = 1; cnt = 0; rc = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); cnt += ale; rc += core_rst; end
    rst_pin = 0;
    chk("R1 short pulse gives no reset", rc, 0);
    chk("R1 bus keeps running during short pulse", int'(cnt > 0), 1);

    do_reset(1'b0);
    run_txn(2'b00, 1'b0, 16'h0100, 8'h00, 8'hC7, 1'b0);
    chk("R7 strap low forces external", rsp_internal, 0);
    run_txn(2'b00, 1'b0, 16'h7FFF, 8'h00, 8'h19, 1'b0);
    run_txn(2'b01, 1'b1, 16'hFF02, 8'h00, 8'hE1, 1'b0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule